// File: doc/BRIEF.md
# Front-End ASIC Configuration Loader

This block writes a fixed-length configuration image into one of several identical readout chips on a front-end board. The image has 1728 bits: a 192-bit global section and a 24-bit section for each of 64 channels. It is kept in a local buffer as eighteen 96-bit words. Words 0 and 1 hold the global section. Words 2 to 17 hold the channel sections in ascending channel order.

The host fills the buffer through a write port. Each write gives a word index and a 96-bit value. The host then pulses a start input together with a chip index. The block pulls the select line of that chip low and keeps it low for the whole image. It streams all eighteen words over a serial clock and data pair, with no pause between words. Each word goes out most significant bit first. When the last bit has been clocked, the block releases the select line and raises a one-cycle completion pulse.

The serial clock rests low. It runs at the system clock divided by an even parameter. Data changes only when the serial clock falls, so each receiver samples it on the rising edge.

Top module: `asic_cfg_loader`

## Requirements
- R1: After reset, every select line is high, the serial clock is low, and both busy and done are low.
- R2: A write with an index from 0 to 17 stores the 96-bit value at that index. A write with an index from 18 to 31 changes no stored word.
- R3: Serial bit k of a transfer equals bit (95 − k mod 96) of buffer word ⌊k/96⌋. Words are therefore sent in order 0 to 17, each starting at its bit 95.
- R4: During a transfer, only the select line numbered by the chip index given at start is low. It stays low without a gap from the start cycle until the release cycle. Outside a transfer, all select lines are high.
- R5: The serial clock is low whenever the block is idle. A full serial clock period lasts SCLK_DIV system cycles. The data output changes during a transfer only in the cycle where the serial clock falls.
- R6: A transfer produces exactly 1728 rising serial clock edges. Busy stays high for exactly 1728 × SCLK_DIV system cycles.
- R7: A start request made while busy is high is ignored. The select lines and the bit stream of the running transfer do not change.
- R8: Done is high for exactly one cycle. That cycle is the first cycle in which busy is low and all select lines are high again after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 5 | Word index for the write (0 to 17 valid) |
| wr_data | input | 96 | Word value to store |
| start | input | 1 | Transfer request, sampled when idle |
| chip_idx | input | 2 | Target chip for the transfer |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, changes on falling edge |
| cs_n | output | 4 | Active-low select, one per chip |

## Verification
The bench builds the block with its default parameters: four chips and SCLK_DIV = 4. This divisor puts the rising and falling serial clock points on different system cycles, so a misplaced edge or an off-by-one in the half period changes the measured busy length. Random images are loaded and sent to chips 0 and 3 and to the chips in between. This covers the word hand-off at every 96-bit boundary and the hand-off from the global words to the channel words. Directed cases add a start request with a different chip in the middle of a transfer, and writes to indices past the buffer end.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } eng_state_t;
endpackage

// File: rtl/cfg_word_buf.sv
module cfg_word_buf #(
   parameter int WORD_W  = 96,
   parameter int N_WORDS = 18,
   parameter int IDX_W   = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [N_WORDS];

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_idx) < N_WORDS))
         mem[wr_idx] <= wr_data;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_WORDS; i++)
         if (int'(rd_idx) == i) rd_data = mem[i];
   end
endmodule

// File: rtl/cfg_sclk_div.sv
module cfg_sclk_div #(
   parameter int SCLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic rise_tick,
   output logic fall_tick
);
   generate
      if (SCLK_DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ph <= 1'b0;
            else if (!en) ph <= 1'b0;
            else          ph <= ~ph;
         end
         assign rise_tick = en && !ph;
         assign fall_tick = en && ph;
      end else begin : g_count
         localparam int CNT_W = $clog2(SCLK_DIV);
         localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(SCLK_DIV/2 - 1);
         localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(SCLK_DIV - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (!en)              cnt <= '0;
            else if (cnt == FULL_M1)   cnt <= '0;
            else                       cnt <= cnt + 1'b1;
         end
         assign rise_tick = en && (cnt == HALF_M1);
         assign fall_tick = en && (cnt == FULL_M1);
      end
   endgenerate
endmodule

// File: rtl/cfg_shift_engine.sv
module cfg_shift_engine
   import cfg_loader_pkg::*;
#(
   parameter int WORD_W  = 96,
   parameter int N_WORDS = 18,
   parameter int IDX_W   = 5,
   parameter int N_CHIPS = 4,
   parameter int CHIP_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CHIP_W-1:0] chip_idx,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic [WORD_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              active,
   output logic              done,
   output logic              sclk,
   output logic              sdo,
   output logic [N_CHIPS-1:0] cs_n
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
   localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(N_WORDS - 1);

   eng_state_t        state;
   logic [IDX_W-1:0]  word_q;
   logic [BIT_W-1:0]  bit_q;
   logic [WORD_W-1:0] shreg;
   logic              accept;

   assign accept = (state == ST_IDLE) && start && (int'(chip_idx) < N_CHIPS);
   assign rd_idx = (state == ST_IDLE || word_q == LAST_WORD) ? '0 : word_q + 1'b1;
   assign active = (state == ST_SHIFT);
   assign sdo    = shreg[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         word_q <= '0;
         bit_q  <= '0;
         shreg  <= '0;
         sclk   <= 1'b0;
         done   <= 1'b0;
         cs_n   <= '1;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state  <= ST_SHIFT;
            word_q <= '0;
            bit_q  <= '0;
            shreg  <= rd_data;
            for (int i = 0; i < N_CHIPS; i++)
               cs_n[i] <= (int'(chip_idx) != i);
         end else if (state == ST_SHIFT) begin
            if (rise_tick) sclk <= 1'b1;
            if (fall_tick) begin
               sclk <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  bit_q <= '0;
                  if (word_q == LAST_WORD) begin
                     state <= ST_IDLE;
                     cs_n  <= '1;
                     done  <= 1'b1;
                     shreg <= '0;
                  end else begin
                     word_q <= word_q + 1'b1;
                     shreg  <= rd_data;
                  end
               end else begin
                  bit_q <= bit_q + 1'b1;
                  shreg <= {shreg[WORD_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/asic_cfg_loader.sv
module asic_cfg_loader #(
   parameter int GLOBAL_BITS = 192,
   parameter int CHAN_BITS   = 24,
   parameter int N_CHAN      = 64,
   parameter int WORD_W      = 96,
   parameter int N_CHIPS     = 4,
   parameter int SCLK_DIV    = 4,
   localparam int TOTAL_BITS = GLOBAL_BITS + CHAN_BITS * N_CHAN,
   localparam int N_WORDS    = TOTAL_BITS / WORD_W,
   localparam int IDX_W      = $clog2(N_WORDS),
   localparam int CHIP_W     = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               start,
   input  logic [CHIP_W-1:0]  chip_idx,
   output logic               busy,
   output logic               done,
   output logic               sclk,
   output logic               sdo,
   output logic [N_CHIPS-1:0] cs_n
);
   generate
      if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("SCLK_DIV must be even and at least 2");
      end
      if ((TOTAL_BITS % WORD_W) != 0) begin : g_bad_pack
         $error("image length must be a whole number of words");
      end
      if (GLOBAL_BITS % WORD_W != 0) begin : g_bad_global
         $error("global section must fill whole words");
      end
      if (N_CHIPS < 1) begin : g_bad_chips
         $error("N_CHIPS must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0]  rd_idx;
   logic [WORD_W-1:0] rd_data;
   logic              rise_tick, fall_tick;

   cfg_word_buf #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_buf (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   cfg_sclk_div #(.SCLK_DIV(SCLK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .en(busy),
      .rise_tick(rise_tick), .fall_tick(fall_tick)
   );

   cfg_shift_engine #(
      .WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W),
      .N_CHIPS(N_CHIPS), .CHIP_W(CHIP_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .chip_idx(chip_idx),
      .rise_tick(rise_tick), .fall_tick(fall_tick),
      .rd_data(rd_data), .rd_idx(rd_idx),
      .active(busy), .done(done), .sclk(sclk), .sdo(sdo), .cs_n(cs_n)
   );
endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
   parameter int N_CHIPS    = 4,
   parameter int TOTAL_BITS = 1728
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               sclk,
   input logic               sdo,
   input logic [N_CHIPS-1:0] cs_n
);
   logic        sclk_q;
   logic [15:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= sclk;
         if (done)              rise_cnt <= '0;
         else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
   end

   assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(~cs_n) == 1));
   assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cs_n));
   assert_select_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cs_n));
   assert_idle_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(sclk)) |-> $stable(sdo));
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_edge_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rise_cnt == 16'(TOTAL_BITS)));
endmodule

bind asic_cfg_loader cfg_loader_checker #(
   .N_CHIPS(N_CHIPS), .TOTAL_BITS(TOTAL_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .sclk(sclk), .sdo(sdo), .cs_n(cs_n)
);

// File: tb/tb_asic_cfg_loader.sv
`timescale 1ns/1ps
module tb_asic_cfg_loader;
   localparam int NW    = 18;
   localparam int WW    = 96;
   localparam int TOT   = 1728;
   localparam int DIV   = 4;
   localparam int NCH   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_idx = '0;
   logic [WW-1:0] wr_data = '0;
   logic          start = 1'b0;
   logic [1:0]    chip_idx = '0;
   logic          busy, done, sclk, sdo;
   logic [NCH-1:0] cs_n;

   asic_cfg_loader #(.SCLK_DIV(DIV), .N_CHIPS(NCH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .start(start), .chip_idx(chip_idx),
      .busy(busy), .done(done), .sclk(sclk), .sdo(sdo), .cs_n(cs_n)
   );

   always #10 clk = ~clk;

   logic [WW-1:0] img [NW];
   int n_chk = 0, n_fail = 0;
   int cap_n = 0, bit_err = 0;
   bit finished = 1'b0;

   function automatic logic exp_bit(int k);
      return img[k / WW][WW - 1 - (k % WW)];
   endfunction

   always @(posedge sclk) begin
      if (cap_n < TOT && sdo !== exp_bit(cap_n)) bit_err++;
      cap_n++;
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(int idx, logic [WW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_random();
      for (int i = 0; i < NW; i++) begin
         img[i] = {$urandom, $urandom, $urandom};
         wr(i, img[i]);
      end
   endtask

   task automatic xfer(int chip, int intruder);
      int busy_cyc = 0, bad_cs = 0, done_w = 0;
      logic [NCH-1:0] mask;
      mask = ~(NCH'(1) << chip);
      cap_n = 0; bit_err = 0;
      @(negedge clk);
      start = 1'b1; chip_idx = 2'(chip);
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (done) break;
         if (busy) busy_cyc++;
         if (busy && cs_n !== mask) bad_cs++;
         if (intruder >= 0 && busy_cyc == 300) begin
            start = 1'b1; chip_idx = 2'(intruder);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(cs_n === '1 && busy === 1'b0, "R8", "release at done", longint'(cs_n), 15);
      @(negedge clk);
      if (done) done_w = 2; else done_w = 1;
      chk(done_w == 1, "R8", "done width", done_w, 1);
      chk(cap_n == TOT, "R6", "rising sclk edges", cap_n, TOT);
      chk(busy_cyc == TOT * DIV, "R6", "busy cycles", busy_cyc, TOT * DIV);
      chk(bit_err == 0, "R3", "stream bit mismatches", bit_err, 0);
      chk(bad_cs == 0, intruder >= 0 ? "R7" : "R4", "select cycles wrong", bad_cs, 0);
      chk(sclk === 1'b0, "R5", "sclk idle low", longint'(sclk), 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs_n === '1, "R1", "cs_n after reset", longint'(cs_n), 15);
      chk(sclk === 1'b0, "R1", "sclk after reset", longint'(sclk), 0);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset",
          longint'({busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: random images to several chips
      load_random();
      xfer(0, -1);
      load_random();
      xfer(3, -1);
      load_random();
      xfer(1, -1);

      // R3: directed walking patterns, word boundaries distinct
      for (int i = 0; i < NW; i++) begin
         img[i] = (i % 2 == 0) ? {WW{1'b1}} ^ WW'(i) : {48{2'b10}} ^ (WW'(i) << 90);
         wr(i, img[i]);
      end
      xfer(2, -1);

      // R7: start with another chip mid-transfer is ignored
      load_random();
      xfer(1, 3);

      // R2: writes past the last index leave the image unchanged
      for (int i = NW; i < 32; i++) wr(i, {$urandom, $urandom, $urandom});
      xfer(0, -1);

      // R2: overwrite a single global and a single channel word
      img[1]  = {$urandom, $urandom, $urandom};
      img[17] = {$urandom, $urandom, $urandom};
      wr(1, img[1]);
      wr(17, img[17]);
      xfer(3, -1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule